// File: doc/BRIEF.md
# Context-Switch Microprogram Sequencer

This block steps through a microprogram of 32-bit instruction words held in an internal store. The host fills the store through a pointer register and a data register. Each data write stores one word at the pointer and moves the pointer on by one. After a start pulse, the sequencer decodes the words one at a time. It can move through runs of engine registers, load a 20-bit count register, branch, wait on or set one bit of a 128-entry flag file, and emit side commands. It stops on an end word or on an instruction it does not know.

All flow control tests one flag selected by a 7-bit index, with a polarity bit taken from each instruction. Flag 104 is tied to one, so a branch on it always goes. Flag 96 shows the engine's busy state, taken from an external idle line. Flag 0 gives the transfer direction. Register transfers are not carried out here. They only appear as a stream of requests, each with a register address and a direction bit, and a ready handshake paces that stream.

Top module: `ctxsw_seq`

## Requirements
- R1: A write to the pointer register (`host_idx_we`) sets the store pointer. Each data write (`host_data_we`) stores the word at the pointer and then adds one to the pointer.
- R2: On `start` while idle, the program counter clears to 0 and `busy` rises. `busy` falls when the program ends or faults. A `start` while busy has no effect. A program costs two cycles per instruction, plus one cycle per transfer request accepted.
- R3: A word with bits 23:20 = 1 issues one request for each of count = bits 19:14 registers. The first address is bits 13:0, and each later address is one higher. Each request is held stable until `xfer_ready`. A count of 0 issues no request.
- R4: `xfer_save` carries the value of flag 0 taken when the transfer starts (1 = save, 0 = load).
- R5: A word with bits 23:20 = 2 copies bits 19:0 into `lsr_value`.
- R6: A word with bits 23:20 = 4 tests the flag indexed by bits 6:0. When that flag differs from bit 7, the program counter loads bits 15:8. Otherwise it steps by one.
- R7: A word with bits 23:20 = 5 stalls until the indexed flag (bits 6:0) equals bit 7.
- R8: A word with bits 23:20 = 7 writes bit 7 into the flag indexed by bits 6:0. The host can also write any flag, and it reads flags back through a registered read port.
- R9: Flag 104 always reads 1. Flag 96 reads the inverse of `eng_idle`. Writes to either flag are ignored.
- R10: A word with bits 23:20 = 6 that is not the end word gives a one-cycle `cmd_valid` with `cmd_code` = bits 7:0.
- R11: A word whose bits 23:0 equal 0x60000E gives a one-cycle `done` and drops `busy`.
- R12: A word with bits 23:20 equal to 0, 3 or 8 to 15, or with any of bits 31:24 set, raises `err` and drops `busy` without `done`. `err` stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start the program at word 0 |
| eng_idle | input | 1 | Engine idle line, shown inverted on flag 96 |
| host_idx_we | input | 1 | Write the store pointer |
| host_idx_wdata | input | 8 | New store pointer |
| host_data_we | input | 1 | Write a word at the pointer and advance it |
| host_data_wdata | input | 32 | Instruction word |
| host_flag_we | input | 1 | Host flag write strobe |
| host_flag_widx | input | 7 | Flag index to write |
| host_flag_wval | input | 1 | Value to write |
| host_flag_ridx | input | 7 | Flag index to read |
| host_flag_rval | output | 1 | Registered flag read value |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Transfer request accepted |
| xfer_addr | output | 14 | Register word index of the request |
| xfer_save | output | 1 | Direction: 1 save, 0 load |
| cmd_valid | output | 1 | Side command strobe |
| cmd_code | output | 8 | Side command code |
| lsr_value | output | 20 | Count/shift register |
| busy | output | 1 | Program running |
| done | output | 1 | End-of-program pulse |
| err | output | 1 | Unknown instruction seen |

## Verification
A context-switch-style program is run three ways: with the save flag set, with the load flag set, and with neither. A wrong branch polarity sends each run down the wrong path, and the stream of transfer directions or commands then differs from the model. Back-pressure on the request handshake catches a design that steps the address or drops a request while ready is low. A count-zero transfer exposes a design that issues one spurious request. A stalled wait on the idle flag, hit with a stray start pulse, catches a design that restarts mid-program, because the first command would then appear twice. Writes to the tied flags, and both kinds of illegal word, check that the fixed flags hold their values and that a fault ends without `done`.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;
  localparam int INSTR_W = 32;
  localparam int XA_W    = 14;
  localparam int CNT_W   = 6;
  localparam int IMM_W   = 20;
  localparam int CODE_W  = 8;

  localparam logic [3:0] OP_XFER = 4'h1;
  localparam logic [3:0] OP_LSR  = 4'h2;
  localparam logic [3:0] OP_BRA  = 4'h4;
  localparam logic [3:0] OP_WAIT = 4'h5;
  localparam logic [3:0] OP_SPEC = 4'h6;
  localparam logic [3:0] OP_SET  = 4'h7;

  localparam logic [23:0] END_WORD = 24'h60000E;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC, ST_XFER} seq_state_e;
endpackage

// File: rtl/ctxsw_store.sv
module ctxsw_store #(
  parameter int DEPTH = 256,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idx_we,
  input  logic [AW-1:0] idx_wdata,
  input  logic          data_we,
  input  logic [W-1:0]  data_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr;

  always_ff @(posedge clk) begin
    if (rst)          wptr <= '0;
    else if (idx_we)  wptr <= idx_wdata;
    else if (data_we) wptr <= wptr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (data_we && !idx_we) mem[wptr] <= data_wdata;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

  p_wptr_step_r1: assert property (@(posedge clk) disable iff (rst)
    (data_we && !idx_we) |=> (wptr == $past(wptr) + AW'(1)));
  p_wptr_load_r1: assert property (@(posedge clk) disable iff (rst)
    idx_we |=> (wptr == $past(idx_wdata)));
endmodule

// File: rtl/ctxsw_flags.sv
module ctxsw_flags #(
  parameter int N          = 128,
  parameter int ALWAYS_IDX = 104,
  parameter int IDLE_IDX   = 96,
  parameter int DIR_IDX    = 0,
  localparam int IW        = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eng_idle,
  input  logic [IW-1:0] seq_idx,
  output logic          seq_val,
  input  logic          seq_we,
  input  logic          seq_wval,
  output logic          dir_val,
  input  logic          host_we,
  input  logic [IW-1:0] host_widx,
  input  logic          host_wval,
  input  logic [IW-1:0] host_ridx,
  output logic          host_rval
);
  logic [N-1:0] view;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == ALWAYS_IDX) begin : g_one
      assign view[i] = 1'b1;
    end else if (i == IDLE_IDX) begin : g_idle
      assign view[i] = ~eng_idle;
    end else begin : g_ff
      logic q;
      always_ff @(posedge clk) begin
        if (rst)                                q <= 1'b0;
        else if (seq_we && seq_idx == IW'(i))   q <= seq_wval;
        else if (host_we && host_widx == IW'(i)) q <= host_wval;
      end
      assign view[i] = q;
    end
  end

  assign seq_val = view[seq_idx];
  assign dir_val = view[DIR_IDX];

  always_ff @(posedge clk) begin
    if (rst) host_rval <= 1'b0;
    else     host_rval <= view[host_ridx];
  end

  p_always_read_r9: assert property (@(posedge clk) disable iff (rst)
    (host_ridx == IW'(ALWAYS_IDX)) |=> host_rval);
  p_seq_write_r8: assert property (@(posedge clk) disable iff (rst)
    (seq_we && seq_idx == IW'(DIR_IDX)) |=> (dir_val == $past(seq_wval)));
endmodule

// File: rtl/ctxsw_seq.sv
module ctxsw_seq
  import ctxsw_pkg::*;
#(
  parameter int PROG_DEPTH = 256,
  parameter int NUM_FLAGS  = 128,
  parameter int ALWAYS_IDX = 104,
  parameter int IDLE_IDX   = 96,
  parameter int DIR_IDX    = 0,
  localparam int PC_W      = $clog2(PROG_DEPTH),
  localparam int FI_W      = $clog2(NUM_FLAGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                eng_idle,
  input  logic                host_idx_we,
  input  logic [PC_W-1:0]     host_idx_wdata,
  input  logic                host_data_we,
  input  logic [INSTR_W-1:0]  host_data_wdata,
  input  logic                host_flag_we,
  input  logic [FI_W-1:0]     host_flag_widx,
  input  logic                host_flag_wval,
  input  logic [FI_W-1:0]     host_flag_ridx,
  output logic                host_flag_rval,
  output logic                xfer_valid,
  input  logic                xfer_ready,
  output logic [XA_W-1:0]     xfer_addr,
  output logic                xfer_save,
  output logic                cmd_valid,
  output logic [CODE_W-1:0]   cmd_code,
  output logic [IMM_W-1:0]    lsr_value,
  output logic                busy,
  output logic                done,
  output logic                err
);
  seq_state_e          state;
  logic [PC_W-1:0]     pc;
  logic [INSTR_W-1:0]  instr;
  logic [CNT_W-1:0]    remain;
  logic                flag_val;
  logic                dir_val;
  logic                set_we;

  logic [3:0]          opc;
  logic [7:0]          hi_byte;
  logic                pol;
  logic [FI_W-1:0]     fidx;
  logic [PC_W-1:0]     target;
  logic [CNT_W-1:0]    cnt;

  assign opc     = instr[23:20];
  assign hi_byte = instr[31:24];
  assign pol     = instr[7];
  assign fidx    = instr[FI_W-1:0];
  assign target  = instr[8 +: PC_W];
  assign cnt     = instr[XA_W +: CNT_W];
  assign set_we  = (state == ST_EXEC) && (hi_byte == 8'd0) && (opc == OP_SET);

  ctxsw_store #(.DEPTH(PROG_DEPTH), .W(INSTR_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .idx_we     (host_idx_we),
    .idx_wdata  (host_idx_wdata),
    .data_we    (host_data_we),
    .data_wdata (host_data_wdata),
    .rd_addr    (pc),
    .rd_data    (instr)
  );

  ctxsw_flags #(
    .N(NUM_FLAGS), .ALWAYS_IDX(ALWAYS_IDX), .IDLE_IDX(IDLE_IDX), .DIR_IDX(DIR_IDX)
  ) u_flags (
    .clk       (clk),
    .rst       (rst),
    .eng_idle  (eng_idle),
    .seq_idx   (fidx),
    .seq_val   (flag_val),
    .seq_we    (set_we),
    .seq_wval  (pol),
    .dir_val   (dir_val),
    .host_we   (host_flag_we),
    .host_widx (host_flag_widx),
    .host_wval (host_flag_wval),
    .host_ridx (host_flag_ridx),
    .host_rval (host_flag_rval)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      pc         <= '0;
      remain     <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd_code   <= '0;
      xfer_valid <= 1'b0;
      xfer_addr  <= '0;
      xfer_save  <= 1'b0;
      lsr_value  <= '0;
    end else begin
      done      <= 1'b0;
      cmd_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            pc    <= '0;
            busy  <= 1'b1;
            err   <= 1'b0;
            state <= ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_EXEC;
        ST_EXEC: begin
          if (hi_byte != 8'd0) begin
            err   <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            case (opc)
              OP_XFER: begin
                if (cnt == '0) begin
                  pc    <= pc + PC_W'(1);
                  state <= ST_FETCH;
                end else begin
                  xfer_valid <= 1'b1;
                  xfer_addr  <= instr[XA_W-1:0];
                  xfer_save  <= dir_val;
                  remain     <= cnt;
                  state      <= ST_XFER;
                end
              end
              OP_LSR: begin
                lsr_value <= instr[IMM_W-1:0];
                pc        <= pc + PC_W'(1);
                state     <= ST_FETCH;
              end
              OP_BRA: begin
                pc    <= (flag_val != pol) ? target : pc + PC_W'(1);
                state <= ST_FETCH;
              end
              OP_WAIT: begin
                if (flag_val == pol) begin
                  pc    <= pc + PC_W'(1);
                  state <= ST_FETCH;
                end
              end
              OP_SET: begin
                pc    <= pc + PC_W'(1);
                state <= ST_FETCH;
              end
              OP_SPEC: begin
                if (instr[23:0] == END_WORD) begin
                  done  <= 1'b1;
                  busy  <= 1'b0;
                  state <= ST_IDLE;
                end else begin
                  cmd_valid <= 1'b1;
                  cmd_code  <= instr[CODE_W-1:0];
                  pc        <= pc + PC_W'(1);
                  state     <= ST_FETCH;
                end
              end
              default: begin
                err   <= 1'b1;
                busy  <= 1'b0;
                state <= ST_IDLE;
              end
            endcase
          end
        end
        ST_XFER: begin
          if (xfer_ready) begin
            if (remain == CNT_W'(1)) begin
              xfer_valid <= 1'b0;
              pc         <= pc + PC_W'(1);
              state      <= ST_FETCH;
            end else begin
              xfer_addr <= xfer_addr + XA_W'(1);
              remain    <= remain - CNT_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_xfer_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_save)));
  p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && xfer_ready && remain > CNT_W'(1)) |=> (xfer_valid && xfer_addr == $past(xfer_addr) + XA_W'(1)));
  p_xfer_busy_r3: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> busy);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !err));
  p_err_stop_r12: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && !xfer_valid));
  p_cmd_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);
endmodule

// File: tb/tb_ctxsw_seq.sv
module tb_ctxsw_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 0, eng_idle = 1;
  logic host_idx_we = 0, host_data_we = 0, host_flag_we = 0, host_flag_wval = 0;
  logic [7:0]  host_idx_wdata = 0;
  logic [31:0] host_data_wdata = 0;
  logic [6:0]  host_flag_widx = 0, host_flag_ridx = 0;
  logic        host_flag_rval;
  logic        xfer_valid, xfer_ready = 1, xfer_save;
  logic [13:0] xfer_addr;
  logic        cmd_valid, busy, done, err;
  logic [7:0]  cmd_code;
  logic [19:0] lsr_value;

  always #4 clk = ~clk;

  ctxsw_seq dut (.*);

  int tests = 0, fails = 0;
  logic [31:0] img [256];
  bit          mflags [128];
  logic [19:0] m_lsr = 0;
  logic [14:0] xq [$];
  logic [7:0]  cq [$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] e_xfer(int c, int a); return 32'h0010_0000 | (c << 14) | a; endfunction
  function automatic logic [31:0] e_lsr(int v); return 32'h0020_0000 | v; endfunction
  function automatic logic [31:0] e_bra(int f, int clr, int t); return 32'h0040_0000 | (t << 8) | (clr << 7) | f; endfunction
  function automatic logic [31:0] e_wait(int f, int v); return 32'h0050_0000 | (v << 7) | f; endfunction
  function automatic logic [31:0] e_set(int f, int v); return 32'h0070_0000 | (v << 7) | f; endfunction
  function automatic logic [31:0] e_cmd(int b); return 32'h0060_0000 | b; endfunction
  localparam logic [31:0] E_END = 32'h0060_000E;

  function automatic bit mf(int i);
    if (i == 104) return 1'b1;
    if (i == 96)  return ~eng_idle;
    return mflags[i];
  endfunction

  task automatic model_run(output int cyc, output bit ends, output bit hang);
    int pc = 0;
    logic [31:0] w;
    cyc = 0; ends = 0; hang = 1;
    for (int steps = 0; steps < 4000; steps++) begin
      w = img[pc];
      cyc += 2;
      if (w[31:24] != 0) begin hang = 0; return; end
      case (w[23:20])
        4'h1: begin
          for (int k = 0; k < int'(w[19:14]); k++)
            xq.push_back({mflags[0], 14'(int'(w[13:0]) + k)});
          cyc += int'(w[19:14]);
          pc++;
        end
        4'h2: begin m_lsr = w[19:0]; pc++; end
        4'h4: pc = (mf(int'(w[6:0])) != w[7]) ? int'(w[15:8]) : pc + 1;
        4'h5: if (mf(int'(w[6:0])) == w[7]) pc++; else return;
        4'h7: begin
          if (w[6:0] != 96 && w[6:0] != 104) mflags[w[6:0]] = w[7];
          pc++;
        end
        4'h6: begin
          if (w[23:0] == 24'h60000E) begin ends = 1; hang = 0; return; end
          cq.push_back(w[7:0]);
          pc++;
        end
        default: begin hang = 0; return; end
      endcase
      pc = pc & 255;
    end
  endtask

  task automatic load_range(int base, int n);
    @(negedge clk); host_idx_we = 1; host_idx_wdata = 8'(base);
    @(negedge clk); host_idx_we = 0;
    for (int i = 0; i < n; i++) begin
      host_data_we = 1; host_data_wdata = img[(base + i) & 255];
      @(negedge clk);
    end
    host_data_we = 0;
  endtask

  task automatic flag_write(int i, bit v);
    @(negedge clk); host_flag_we = 1; host_flag_widx = 7'(i); host_flag_wval = v;
    if (i != 96 && i != 104) mflags[i] = v;
    @(negedge clk); host_flag_we = 0;
  endtask

  task automatic flag_read(input int i, output logic v);
    @(negedge clk); host_flag_ridx = 7'(i);
    @(negedge clk); v = host_flag_rval;
  endtask

  task automatic run_prog(input string name, input bit bp, input bit chk_cyc);
    int ecyc, cyc;
    bit eend, hang;
    logic [14:0] ex;
    model_run(ecyc, eend, hang);
    if (hang) chk({name, " R7 model hang"}, 1, 0);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    cyc = 0;
    forever begin
      xfer_ready = bp ? ((cyc % 3) != 1) : 1'b1;
      #1;
      cyc++;
      if (xfer_valid && xfer_ready) begin
        if (xq.size() == 0) chk({name, " R3 unexpected request"}, 1, 0);
        else begin
          ex = xq.pop_front();
          chk({name, " R3 xfer_addr"}, 32'(xfer_addr), 32'(ex[13:0]));
          chk({name, " R4 xfer_save"}, 32'(xfer_save), 32'(ex[14]));
        end
      end
      if (cmd_valid) begin
        if (cq.size() == 0) chk({name, " R10 unexpected cmd"}, 1, 0);
        else chk({name, " R10 cmd_code"}, 32'(cmd_code), 32'(cq.pop_front()));
      end
      if (done || err) break;
      if (cyc > 6000) begin chk({name, " R2 program never finished"}, 1, 0); break; end
      @(negedge clk);
    end
    xfer_ready = 1;
    chk({name, " R11 done"}, 32'(done), 32'(eend));
    chk({name, " R12 err"}, 32'(err), 32'(!eend));
    chk({name, " R2 busy low"}, 32'(busy), 0);
    chk({name, " R3 requests left"}, xq.size(), 0);
    chk({name, " R10 cmds left"}, cq.size(), 0);
    chk({name, " R5 lsr_value"}, 32'(lsr_value), 32'(m_lsr));
    if (chk_cyc) chk({name, " R2 cycle count"}, cyc, ecyc + 1);
    xq.delete(); cq.delete();
  endtask

  initial begin
    #(8 * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic v;
    int ncmd;
    for (int i = 0; i < 256; i++) img[i] = E_END;
    for (int i = 0; i < 128; i++) mflags[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R2 reset busy", 32'(busy), 0);
    chk("R11 reset done", 32'(done), 0);
    chk("R12 reset err", 32'(err), 0);
    chk("R3 reset xfer_valid", 32'(xfer_valid), 0);
    chk("R5 reset lsr", 32'(lsr_value), 0);

    // context-switch style program (R1 full load through pointer 0)
    img[0] = e_bra(100, 0, 5);  img[1] = e_bra(5, 0, 5);   img[2] = e_bra(6, 0, 7);
    img[3] = e_bra(104, 0, 12); img[4] = E_END;            img[5] = e_set(0, 1);
    img[6] = e_bra(104, 0, 8);  img[7] = e_set(0, 0);      img[8] = e_xfer(3, 14'h100);
    img[9] = e_lsr(20'h12345);  img[10] = e_xfer(2, 14'h3FFE); img[11] = e_cmd(8'h09);
    img[12] = e_set(5, 0);      img[13] = e_set(6, 0);     img[14] = E_END;
    load_range(0, 256);

    flag_write(5, 1);
    run_prog("save", 0, 1);
    flag_read(0, v);  chk("R8 dir flag set by program", 32'(v), 1);
    flag_read(5, v);  chk("R8 save flag cleared by program", 32'(v), 0);

    flag_write(6, 1);
    run_prog("load", 0, 1);
    run_prog("exit", 0, 1);
    flag_write(100, 1);
    run_prog("autosave backpressure", 1, 0);
    flag_write(100, 0);

    // R1 pointer at 40, R6 polarity, R3 count zero
    img[0] = e_bra(104, 0, 40);
    img[40] = e_bra(7, 1, 43); img[41] = e_cmd(8'hAA); img[42] = E_END;
    img[43] = e_cmd(8'hBB);    img[44] = e_xfer(0, 5); img[45] = e_bra(104, 1, 41);
    img[46] = E_END;
    load_range(40, 7);
    load_range(0, 1);
    run_prog("R6 clear taken", 0, 1);
    flag_write(7, 1);
    run_prog("R6 clear not taken", 0, 1);

    // R9 tied flags
    flag_write(104, 0);
    flag_read(104, v); chk("R9 flag 104 reads one", 32'(v), 1);
    eng_idle = 1;
    flag_write(96, 1);
    flag_read(96, v);  chk("R9 flag 96 inverse idle", 32'(v), 0);
    eng_idle = 0;
    flag_read(96, v);  chk("R9 flag 96 follows idle", 32'(v), 1);

    // R7 wait on idle, R2 start ignored while busy
    img[0] = e_cmd(8'h11); img[1] = e_wait(96, 0); img[2] = e_cmd(8'h22); img[3] = E_END;
    load_range(0, 4);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    ncmd = 0;
    for (int i = 0; i < 30; i++) begin
      if (i == 12) start = 1;
      if (i == 13) start = 0;
      #1;
      if (cmd_valid) begin ncmd++; chk("R10 first cmd", 32'(cmd_code), 32'h11); end
      @(negedge clk);
    end
    chk("R7 stalled cmds", ncmd, 1);
    chk("R7 still busy", 32'(busy), 1);
    eng_idle = 1;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (cmd_valid) begin ncmd++; chk("R2 no restart cmd", 32'(cmd_code), 32'h22); end
      if (done) break;
      @(negedge clk);
    end
    chk("R7 released done", 32'(done), 1);
    chk("R2 cmd total", ncmd, 2);

    // R12 illegal opcode and nonzero upper byte
    img[0] = e_cmd(8'h01); img[1] = 32'h0030_0000;
    load_range(0, 2);
    run_prog("R12 opcode 3", 0, 1);
    repeat (3) @(negedge clk);
    chk("R12 err held", 32'(err), 1);
    img[1] = 32'h0120_0005;
    load_range(1, 1);
    run_prog("R12 upper byte", 0, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule